// File: doc/BRIEF.md
# Power Domain Transition Sequencer

This block owns the run state of a small set of peripheral modules that are grouped into power domains. Software works in two steps. First it stores a wanted state for each module in that module's control word. Then it writes a per-domain go command. The sequencer walks the addressed domain through its transition and shows the domain as busy while the transition runs. At the end it copies the wanted state of every module in that domain into the module's live status. The live status drives one clock-enable line and one reset line per module.

A domain can start out unpowered. If software has marked such a domain for power-on, the go command raises an external power request line for that domain. The transition then holds until software reports power good through the domain control word. Only then does the fixed settling latency start. After the domain has powered up once, later go commands skip the handshake.

Access is through a plain register bus: a word address, a write strobe with write data, and a read strobe. Read data is returned one cycle after the read strobe.

Top module: `pdseq_top`

## Requirements
- R1: After reset, every module status word reads 0. `mod_clk_en` is all 0 and `mod_rst` is all 1. The busy word (0x128) and the request word (0x070) read 0. The domain power word (0x200) reads 1, meaning bit 0 (domain 0) is powered and bit 1 (domain 1) is not.
- R2: A write to the control word of module i (0xA00 + 4*i) stores data bits [4:0], which read back there. The status word of module i (0x800 + 4*i) does not change until a transition of the module's domain completes.
- R3: For a powered domain N, a write with bit N set to 0x120 sets bit N of 0x128 for exactly XFER_LAT (default 4) cycles. The status of that domain's modules takes the values of their control words on the edge where busy drops.
- R4: A transition changes only the modules mapped to the commanded domain. By default modules 0 to 3 are in domain 0 and modules 4 to 7 are in domain 1.
- R5: In a status word, bits [4:0] hold the state and bit 12 reads 1 exactly for states 1 and 3. State codes: 0 = software reset, 1 = synchronous reset, 2 = disabled, 3 = enabled. `mod_clk_en[i]` is 1 for states 1 and 3. `mod_rst[i]` is 1 for states 0 and 1.
- R6: A go command for an unpowered domain N whose control word (0x300 + 4*N) has bit 0 set does three things on the go edge: it sets bit N of 0x070 and of `pwr_req`, and the domain stays busy. Once bit 8 (power good) of that control word has been written to 1, the next edge clears the request and sets bit N of 0x200. XFER_LAT cycles after that, the domain's modules take their new states. A powered domain never raises the request.
- R7: A go command for an unpowered domain whose control bit 0 is clear raises no request. It completes after XFER_LAT cycles with the module states applied, and the domain stays unpowered.
- R8: A go command for a domain that is already busy is ignored, and the running transition ends on its original cycle.
- R9: `bus_rdata` updates only on the edge that samples `bus_rd` and holds otherwise. Unmapped addresses, the go word and module indices of 8 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| mod_clk_en | output | 8 | Per-module clock enable |
| mod_rst | output | 8 | Per-module reset, active high |
| pwr_req | output | 2 | Per-domain external power request |

## Verification
A write is taken on the edge that samples `bus_wr`, and the go command acts on that same edge. For a powered domain, busy is therefore visible on the next XFER_LAT reads of 0x128. The module ports and status words change on the edge where the last busy read is sampled. For an unpowered domain, the request shows right after the go edge. The latency count starts one edge after the power-good write. The bench drives on falling edges and queues every read's expected word in a scoreboard that is compared on the falling edge after the read. It checks the port outputs at the negedge just before and just after the computed commit edge, so that a latency that is off by one cycle shows up.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam int ST_W   = 5;

  // word offsets decoded by software
  localparam logic [BUS_AW-1:0] OFS_PREQ  = 12'h070;
  localparam logic [BUS_AW-1:0] OFS_GO    = 12'h120;
  localparam logic [BUS_AW-1:0] OFS_BUSY  = 12'h128;
  localparam logic [BUS_AW-1:0] OFS_DPWR  = 12'h200;
  localparam logic [BUS_AW-1:0] OFS_DCTL  = 12'h300;
  localparam logic [BUS_AW-1:0] OFS_MSTAT = 12'h800;
  localparam logic [BUS_AW-1:0] OFS_MCTL  = 12'hA00;

  localparam int CLKRUN_BIT = 12;
  localparam int PWRON_BIT  = 0;
  localparam int PGOOD_BIT  = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PWAIT = 2'd1,
    PH_COUNT = 2'd2
  } dom_phase_t;

  // states 1 and 3 keep the module clock running
  function automatic logic st_clk_on(input logic [ST_W-1:0] s);
    return (s == ST_W'(1)) || (s == ST_W'(3));
  endfunction

  // states 0 and 1 hold the module in reset
  function automatic logic st_in_rst(input logic [ST_W-1:0] s);
    return (s == ST_W'(0)) || (s == ST_W'(1));
  endfunction

endpackage

// File: rtl/pdseq_regbus.sv
module pdseq_regbus
  import pdseq_pkg::*;
#(
  parameter int NUM_MOD = 8,
  parameter int NUM_DOM = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [BUS_AW-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [BUS_DW-1:0]              bus_wdata,
  input  logic                           bus_rd,
  output logic [BUS_DW-1:0]              bus_rdata,
  output logic [NUM_MOD-1:0][ST_W-1:0]   mod_want,
  output logic [NUM_DOM-1:0]             dom_on_req,
  output logic [NUM_DOM-1:0]             dom_pgood,
  output logic [NUM_DOM-1:0]             dom_go,
  input  logic [NUM_MOD-1:0][ST_W-1:0]   mod_live,
  input  logic [NUM_DOM-1:0]             dom_busy,
  input  logic [NUM_DOM-1:0]             dom_pwr,
  input  logic [NUM_DOM-1:0]             dom_preq
);

  logic [NUM_MOD-1:0][ST_W-1:0] want_q;
  logic [NUM_MOD-1:0]           want_we;
  logic [NUM_DOM-1:0]           on_q;
  logic [NUM_DOM-1:0]           pg_q;
  logic [NUM_DOM-1:0]           dctl_we;
  logic [BUS_DW-1:0]            rdata_q;
  logic [BUS_DW-1:0]            rdata_nxt;
  logic                         wdata_unused;

  assign wdata_unused = ^bus_wdata;

  // write decode
  always_comb begin
    dom_go  = '0;
    want_we = '0;
    dctl_we = '0;
    if (bus_wr) begin
      if (bus_addr == OFS_GO) dom_go = bus_wdata[NUM_DOM-1:0];
      for (int i = 0; i < NUM_MOD; i++)
        if (bus_addr == OFS_MCTL + BUS_AW'(4*i)) want_we[i] = 1'b1;
      for (int d = 0; d < NUM_DOM; d++)
        if (bus_addr == OFS_DCTL + BUS_AW'(4*d)) dctl_we[d] = 1'b1;
    end
  end

  // module control words
  genvar gi;
  generate
    for (gi = 0; gi < NUM_MOD; gi++) begin : g_want
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             want_q[gi] <= '0;
        else if (want_we[gi])   want_q[gi] <= bus_wdata[ST_W-1:0];
      end
    end
  endgenerate

  // domain control words
  genvar gd;
  generate
    for (gd = 0; gd < NUM_DOM; gd++) begin : g_dctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          on_q[gd] <= 1'b0;
          pg_q[gd] <= 1'b0;
        end else if (dctl_we[gd]) begin
          on_q[gd] <= bus_wdata[PWRON_BIT];
          pg_q[gd] <= bus_wdata[PGOOD_BIT];
        end
      end
    end
  endgenerate

  // read mux
  always_comb begin
    rdata_nxt = '0;
    if (bus_addr == OFS_PREQ) rdata_nxt[NUM_DOM-1:0] = dom_preq;
    if (bus_addr == OFS_BUSY) rdata_nxt[NUM_DOM-1:0] = dom_busy;
    if (bus_addr == OFS_DPWR) rdata_nxt[NUM_DOM-1:0] = dom_pwr;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (bus_addr == OFS_DCTL + BUS_AW'(4*d)) begin
        rdata_nxt[PWRON_BIT] = on_q[d];
        rdata_nxt[PGOOD_BIT] = pg_q[d];
      end
    end
    for (int i = 0; i < NUM_MOD; i++) begin
      if (bus_addr == OFS_MCTL + BUS_AW'(4*i))
        rdata_nxt[ST_W-1:0] = want_q[i];
      if (bus_addr == OFS_MSTAT + BUS_AW'(4*i)) begin
        rdata_nxt[ST_W-1:0]   = mod_live[i];
        rdata_nxt[CLKRUN_BIT] = st_clk_on(mod_live[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_nxt;
  end

  assign bus_rdata  = rdata_q;
  assign mod_want   = want_q;
  assign dom_on_req = on_q;
  assign dom_pgood  = pg_q;

endmodule

// File: rtl/pdseq_dom_seq.sv
module pdseq_dom_seq
  import pdseq_pkg::*;
#(
  parameter int XFER_LAT         = 4,
  parameter bit POWERED_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic on_req,
  input  logic pgood,
  output logic busy,
  output logic powered,
  output logic preq,
  output logic commit
);

  localparam int CNT_W = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_LAT - 1);

  dom_phase_t       ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pwr_q, pwr_n;
  logic             req_q, req_n;
  logic             cnt_en;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    pwr_n  = pwr_q;
    req_n  = req_q;
    commit = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (go) begin
          if (!pwr_q && on_req) begin
            ph_n  = PH_PWAIT;
            req_n = 1'b1;
          end else begin
            ph_n  = PH_COUNT;
            cnt_n = CNT_LOAD;
          end
        end
      end
      PH_PWAIT: begin
        if (pgood) begin
          pwr_n = 1'b1;
          req_n = 1'b0;
          ph_n  = PH_COUNT;
          cnt_n = CNT_LOAD;
        end
      end
      PH_COUNT: begin
        if (cnt_q == '0) begin
          commit = 1'b1;
          ph_n   = PH_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  assign cnt_en = (cnt_n != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      pwr_q <= POWERED_AT_RESET;
      req_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      pwr_q <= pwr_n;
      req_q <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign busy    = (ph_q != PH_IDLE);
  assign powered = pwr_q;
  assign preq    = req_q;

endmodule

// File: rtl/pdseq_mod_slot.sv
module pdseq_mod_slot
  import pdseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [ST_W-1:0] want,
  output logic [ST_W-1:0] live,
  output logic            clk_en,
  output logic            in_rst
);

  logic [ST_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (commit) live_q <= want;
  end

  assign live   = live_q;
  assign clk_en = st_clk_on(live_q);
  assign in_rst = st_in_rst(live_q);

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int NUM_MOD  = 8,
  parameter int NUM_DOM  = 2,
  parameter int XFER_LAT = 4,
  parameter int DOM_IW   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  parameter logic [NUM_MOD*DOM_IW-1:0] MOD_DOM_MAP = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst,
  output logic [NUM_DOM-1:0] pwr_req
);

  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  logic [NUM_MOD-1:0][ST_W-1:0] mod_want;
  logic [NUM_MOD-1:0][ST_W-1:0] mod_live;
  logic [NUM_DOM-1:0]           dom_on_req;
  logic [NUM_DOM-1:0]           dom_pgood;
  logic [NUM_DOM-1:0]           dom_go;
  logic [NUM_DOM-1:0]           dom_busy;
  logic [NUM_DOM-1:0]           dom_pwr;
  logic [NUM_DOM-1:0]           dom_commit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pdseq_regbus #(
    .NUM_MOD(NUM_MOD),
    .NUM_DOM(NUM_DOM)
  ) u_regbus (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .mod_want   (mod_want),
    .dom_on_req (dom_on_req),
    .dom_pgood  (dom_pgood),
    .dom_go     (dom_go),
    .mod_live   (mod_live),
    .dom_busy   (dom_busy),
    .dom_pwr    (dom_pwr),
    .dom_preq   (pwr_req)
  );

  genvar gd;
  generate
    for (gd = 0; gd < NUM_DOM; gd++) begin : g_dom
      pdseq_dom_seq #(
        .XFER_LAT         (XFER_LAT),
        .POWERED_AT_RESET (gd == 0)
      ) u_seq (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .go      (dom_go[gd]),
        .on_req  (dom_on_req[gd]),
        .pgood   (dom_pgood[gd]),
        .busy    (dom_busy[gd]),
        .powered (dom_pwr[gd]),
        .preq    (pwr_req[gd]),
        .commit  (dom_commit[gd])
      );
    end
  endgenerate

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MOD; gi++) begin : g_mod
      localparam int MY_DOM = int'(MOD_DOM_MAP[gi*DOM_IW +: DOM_IW]);
      pdseq_mod_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .commit (dom_commit[MY_DOM]),
        .want   (mod_want[gi]),
        .live   (mod_live[gi]),
        .clk_en (mod_clk_en[gi]),
        .in_rst (mod_rst[gi])
      );
    end
  endgenerate

endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
  parameter int NUM_MOD  = 8,
  parameter int NUM_DOM  = 2,
  parameter int XFER_LAT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [NUM_MOD-1:0] mod_clk_en,
  input logic [NUM_MOD-1:0] mod_rst,
  input logic [NUM_DOM-1:0] pwr_req,
  input logic [NUM_DOM-1:0] dom_busy,
  input logic [NUM_DOM-1:0] dom_pwr,
  input logic [NUM_DOM-1:0] dom_commit
);

  // R9: read data only moves on a sampled read
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R5 / R4: module outputs change only on a completing transition
  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|dom_commit) |=> ($stable(mod_clk_en) && $stable(mod_rst)));

  genvar gd;
  generate
    for (gd = 0; gd < NUM_DOM; gd++) begin : g_dchk
      // R6: a request is raised only for an unpowered, busy domain
      assert_req_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_req[gd] |-> (!dom_pwr[gd] && dom_busy[gd]));

      // R6: power, once good, stays good
      assert_pwr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dom_pwr[gd] |=> dom_pwr[gd]);

      // R3: completion only from a busy domain with no open request
      assert_commit_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dom_commit[gd] |-> (dom_busy[gd] && !pwr_req[gd]));

      if (XFER_LAT > 1) begin : g_min
        // R3: busy lasts more than one cycle
        assert_busy_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(dom_busy[gd]) |=> dom_busy[gd]);
      end
    end
  endgenerate

endmodule

bind pdseq_top pdseq_chk #(
  .NUM_MOD  (NUM_MOD),
  .NUM_DOM  (NUM_DOM),
  .XFER_LAT (XFER_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .mod_clk_en (mod_clk_en),
  .mod_rst    (mod_rst),
  .pwr_req    (pwr_req),
  .dom_busy   (dom_busy),
  .dom_pwr    (dom_pwr),
  .dom_commit (dom_commit)
);

// File: tb/pdseq_top_test.sv
`timescale 1ns/1ps
module pdseq_top_test;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [7:0]  mod_clk_en;
  logic [7:0]  mod_rst;
  logic [1:0]  pwr_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  pdseq_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst(mod_rst), .pwr_req(pwr_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected status word from state code (R5)
  function automatic logic [31:0] stat_word(input logic [4:0] s);
    logic [31:0] w;
    w = {27'd0, s};
    w[12] = (s == 5'd1) || (s == 5'd3);
    return w;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare each read one edge later
  initial begin
    bit pend;
    forever begin
      @(posedge clk);
      pend = bus_rd;
      @(negedge clk);
      if (pend) begin
        if (exp_q.size() == 0) chk("scoreboard empty", 32'h0, 32'h1);
        else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", {24'd0, mod_clk_en}, 32'h00);
    chk("R1 mod_rst", {24'd0, mod_rst}, 32'hFF);
    chk("R1 pwr_req", {30'd0, pwr_req}, 32'h0);
    rd(12'h200, 32'h1, "R1 domain power");
    rd(12'h128, 32'h0, "R1 busy");
    rd(12'h070, 32'h0, "R1 request");
    rd(12'h800, 32'h0, "R1 status m0");
    rd(12'h81C, 32'h0, "R1 status m7");

    // R2 control write and readback
    wr(12'hA00, 32'hFFFF_FFE3);
    wr(12'hA04, 32'h1);
    wr(12'hA08, 32'h2);
    wr(12'hA0C, 32'h0);
    wr(12'hA10, 32'h3);
    rd(12'hA00, 32'h3, "R2 ctl m0");
    rd(12'hA04, 32'h1, "R2 ctl m1");
    rd(12'h800, 32'h0, "R2 status held");

    // R3 go domain 0: busy for 4 reads, commit on the 4th edge
    wr(12'h120, 32'h1);
    rd(12'h128, 32'h1, "R3 busy c1");
    rd(12'h128, 32'h1, "R3 busy c2");
    rd(12'h128, 32'h1, "R3 busy c3");
    chk("R3 outputs before commit", {24'd0, mod_clk_en}, 32'h00);
    rd(12'h128, 32'h1, "R3 busy c4");
    chk("R3 clk_en after commit", {24'd0, mod_clk_en}, 32'h03);
    chk("R5 mod_rst after commit", {24'd0, mod_rst}, 32'hFA);
    rd(12'h128, 32'h0, "R3 busy cleared");
    rd(12'h800, stat_word(5'd3), "R5 status m0 enabled");
    rd(12'h804, stat_word(5'd1), "R5 status m1 sync reset");
    rd(12'h808, stat_word(5'd2), "R5 status m2 disabled");
    rd(12'h80C, stat_word(5'd0), "R5 status m3 sw reset");
    rd(12'h810, 32'h0, "R4 m4 untouched by domain 0");

    // R8 second go while busy is ignored
    wr(12'hA08, 32'h3);
    wr(12'h120, 32'h1);
    rd(12'h128, 32'h1, "R8 busy c1");
    wr(12'h120, 32'h1);
    rd(12'h128, 32'h1, "R8 busy c3");
    rd(12'h128, 32'h1, "R8 busy c4");
    chk("R8 commit on original cycle", {24'd0, mod_clk_en}, 32'h07);
    rd(12'h128, 32'h0, "R8 busy cleared");

    // R7 unpowered domain without power-on intent
    wr(12'h120, 32'h2);
    chk("R7 no request", {30'd0, pwr_req}, 32'h0);
    rd(12'h128, 32'h2, "R7 busy c1");
    rd(12'h128, 32'h2, "R7 busy c2");
    rd(12'h128, 32'h2, "R7 busy c3");
    rd(12'h128, 32'h2, "R7 busy c4");
    rd(12'h128, 32'h0, "R7 busy cleared");
    rd(12'h200, 32'h1, "R7 domain stays off");
    rd(12'h810, stat_word(5'd3), "R7 m4 applied");
    chk("R4 clk_en after domain 1", {24'd0, mod_clk_en}, 32'h17);
    chk("R4 mod_rst after domain 1", {24'd0, mod_rst}, 32'hEA);

    // R6 power handshake
    wr(12'h304, 32'h1);
    wr(12'hA14, 32'h1);
    wr(12'h120, 32'h2);
    chk("R6 request raised", {30'd0, pwr_req}, 32'h2);
    rd(12'h070, 32'h2, "R6 request word");
    rd(12'h128, 32'h2, "R6 busy while waiting");
    repeat (5) @(negedge clk);
    rd(12'h128, 32'h2, "R6 still waiting");
    rd(12'h200, 32'h1, "R6 still off");
    chk("R6 outputs held", {24'd0, mod_clk_en}, 32'h17);
    wr(12'h304, 32'h101);
    rd(12'h128, 32'h2, "R6 busy pg edge");
    rd(12'h070, 32'h0, "R6 request cleared");
    rd(12'h200, 32'h3, "R6 domain powered");
    rd(12'h128, 32'h2, "R6 busy count");
    chk("R6 outputs before commit", {24'd0, mod_clk_en}, 32'h17);
    rd(12'h128, 32'h2, "R6 busy last");
    chk("R6 clk_en after commit", {24'd0, mod_clk_en}, 32'h37);
    rd(12'h128, 32'h0, "R6 busy cleared");
    rd(12'h814, stat_word(5'd1), "R6 status m5");
    rd(12'h304, 32'h101, "R6 domain control readback");

    // R6 powered domain: no request on later go
    wr(12'h120, 32'h2);
    chk("R6 no request when powered", {30'd0, pwr_req}, 32'h0);
    repeat (6) @(negedge clk);
    rd(12'h128, 32'h0, "R6 powered transition done");

    // R9 unmapped addresses
    rd(12'h7FC, 32'h0, "R9 unmapped");
    rd(12'hA20, 32'h0, "R9 module index 8");
    rd(12'h120, 32'h0, "R9 go word");
    repeat (2) @(negedge clk);
    chk("R9 rdata holds", bus_rdata, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule